// File: doc/BRIEF.md
# Pipelined Sum of Two Products

This block is a three-stage arithmetic pipeline. Each clock it can accept one 32-bit word that packs four unsigned 8-bit operands. It returns the product of the two low operands plus the product of the two high operands as a 17-bit result. The operands, the two full-width products and the final sum each sit in their own register stage, so a new word can enter on every cycle.

A single enable stalls the whole pipeline. A valid flag travels with the data through every stage. The consumer qualifies each result with the output valid flag and never has to know where the empty slots are. Upstream logic can feed words continuously, or insert gaps by lowering input valid.

Top module: `prod_sum_pipe`

## Requirements
- R1: With operands b0 = in_word[7:0], b1 = in_word[15:8], b2 = in_word[23:16] and b3 = in_word[31:24], all unsigned, the result is b0*b1 + b2*b3.
- R2: A synchronous reset clears every valid flag. out_valid is 0 on the cycle after reset is sampled high, and it stays 0 until a valid word has passed through all three stages.
- R3: The result is 17 bits wide and never wraps. All four operands at 0xFF give 130050.
- R4: A valid word accepted on an enabled clock edge appears at the output, with out_valid = 1, after exactly three enabled edges. Before that, out_valid stays 0 for that slot.
- R5: While en is 0, the result and out_valid keep their values, so a stall neither loses nor duplicates a result.
- R6: A word presented with in_valid = 0 yields a slot with out_valid = 0, and the gap keeps its place in the stream.
- R7: A continuous stream of valid words with en held high gives one valid result per cycle, in input order.
- R8: Each product keeps all 16 bits. For example, 0xFF*0xFF + 0x01*0x01 gives 65026.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid flags |
| en | input | 1 | Pipeline advance enable; when low, all stages hold |
| in_valid | input | 1 | Marks in_word as a real operand word |
| in_word | input | 32 | Four packed unsigned 8-bit operands |
| result | output | 17 | b0*b1 + b2*b3 |
| out_valid | output | 1 | result holds a real value |

## Verification
On every cycle the assertions check three things: the hold-during-stall rule, the cleared valid after reset, and the end-to-end relation. That relation says that after three enabled, reset-free edges, out_valid equals the input valid of three edges earlier, and the result matches the operands of that word. Only the bench scenarios can show the following: the mapping of operand fields to products, the extreme values, the handling of bubbles, and a full-rate stream. The bench covers these by running directed and random stimulus against a cycle model of the three-slot pipeline, with stalls and a reset in mid-stream.

// File: rtl/prod_sum_pipe.sv
module prod_sum_pipe #(
  parameter int OPW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic [4*OPW-1:0]  in_word,
  output logic [2*OPW:0]    result,
  output logic              out_valid
);
  localparam int PW = 2 * OPW;
  localparam int SW = PW + 1;

  logic [OPW-1:0] op [4];
  logic [PW-1:0]  prod_lo, prod_hi;
  logic [SW-1:0]  sum_q;
  logic [2:0]     vld;

  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 0; k < 4; k++) op[k] <= in_word[k*OPW +: OPW];
      prod_lo <= op[0] * op[1];
      prod_hi <= op[2] * op[3];
      sum_q   <= SW'(prod_lo) + SW'(prod_hi);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     vld <= '0;
    else if (en) vld <= {vld[1:0], in_valid};
  end

  assign result    = sum_q;
  assign out_valid = vld[2];

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> ($stable(result) && $stable(out_valid)));

  a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r4_end_to_end: assert property (@(posedge clk) disable iff (rst)
    ($past(en,1) && $past(en,2) && $past(en,3) &&
     !$past(rst,1) && !$past(rst,2) && !$past(rst,3))
    |-> (out_valid == $past(in_valid,3)) &&
        (!out_valid || result ==
          SW'($past(in_word[OPW-1:0],3)) * SW'($past(in_word[2*OPW-1:OPW],3)) +
          SW'($past(in_word[3*OPW-1:2*OPW],3)) * SW'($past(in_word[4*OPW-1:3*OPW],3))));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result <= SW'(2 * ((1 << OPW) - 1) * ((1 << OPW) - 1))));
endmodule

// File: tb/tb_prod_sum_pipe.sv
module tb_prod_sum_pipe;
  logic        clk = 0;
  logic        rst = 1;
  logic        en = 0;
  logic        in_valid = 0;
  logic [31:0] in_word = '0;
  logic [16:0] result;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit  mv [1:3];
  int  md [1:3];

  always #2 clk = ~clk;

  prod_sum_pipe dut (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
    .in_word(in_word), .result(result), .out_valid(out_valid)
  );

  function automatic int expect_sum(input logic [31:0] w);
    return int'(w[7:0]) * int'(w[15:8]) + int'(w[23:16]) * int'(w[31:24]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic v, input logic [31:0] w, input string tag);
    logic [16:0] r_before;
    logic        v_before;
    en = e; in_valid = v; in_word = w;
    r_before = result;
    v_before = out_valid;
    @(posedge clk);
    if (rst) begin
      mv[1] = 0; mv[2] = 0; mv[3] = 0;
    end else if (e) begin
      mv[3] = mv[2]; md[3] = md[2];
      mv[2] = mv[1]; md[2] = md[1];
      mv[1] = v;     md[1] = expect_sum(w);
    end
    @(negedge clk);
    check(tag, int'(out_valid), int'(mv[3]));
    if (mv[3]) check(tag, int'(result), md[3]);
    if (!e && !rst) begin
      check("R5", int'(result), int'(r_before));
      check("R5", int'(out_valid), int'(v_before));
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    rst = 1;
    step(1, 1, 32'hFFFF_FFFF, "R2");
    step(1, 1, 32'hFFFF_FFFF, "R2");
    rst = 0;
    step(1, 0, 32'h0, "R2");
    step(1, 0, 32'h0, "R2");

    step(1, 1, 32'h0000_0302, "R4");
    step(1, 0, 32'h0, "R4");
    step(1, 0, 32'h0, "R4");
    step(1, 0, 32'h0, "R4");
    step(1, 0, 32'h0, "R4");

    step(1, 1, 32'h0504_0000, "R1");
    step(1, 1, 32'h0000_0302, "R1");
    step(1, 1, 32'h0700_0600, "R1");
    step(1, 1, 32'hFFFF_FFFF, "R3");
    step(1, 1, 32'h0101_FFFF, "R8");
    step(1, 1, 32'h0000_FFFF, "R8");
    step(1, 0, 32'hFFFF_FFFF, "R6");
    step(1, 1, 32'h0203_0405, "R6");
    step(1, 0, 32'h1111_1111, "R6");
    step(1, 0, 32'h0, "R1");
    step(1, 0, 32'h0, "R1");
    step(1, 0, 32'h0, "R3");

    step(1, 1, 32'h0909_0909, "R5");
    step(1, 1, 32'h0A0A_0A0A, "R5");
    step(1, 1, 32'h0B0B_0B0B, "R5");
    step(0, 1, 32'hDEAD_BEEF, "R5");
    step(0, 0, 32'h1234_5678, "R5");
    step(0, 1, 32'hFFFF_FFFF, "R5");
    step(1, 0, 32'h0, "R5");
    step(1, 0, 32'h0, "R5");
    step(1, 0, 32'h0, "R5");

    for (int i = 0; i < 300; i++) step(1, 1, $urandom, "R7");

    for (int i = 0; i < 2000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom, "R6");

    for (int i = 0; i < 2; i++) step(1, 1, $urandom, "R7");
    rst = 1;
    step(1, 1, $urandom, "R2");
    rst = 0;
    step(1, 1, 32'h0102_0304, "R2");
    step(1, 1, 32'h0506_0708, "R2");
    step(1, 1, 32'h0000_0000, "R4");
    step(1, 0, 32'h0, "R4");
    step(1, 0, 32'h0, "R4");
    step(1, 0, 32'h0, "R4");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule